// File: doc/BRIEF.md
# Dual-Bank Memory Port Controller

This block sits between three requesting ports and an on-chip memory built as two 32-bit wide banks, one below and one above a fixed split address. The three ports are a code-bus port (index 0), a system-bus port (index 1) and a backdoor port for non-core masters (index 2). Each request carries an address, a write flag, a byte mask and write data. The block decodes the address to a bank, checks that the port may use that bank, arbitrates when two ports want the same bank, and returns read data one cycle after acceptance.

The lower bank may be used only by the code port and the backdoor. The upper bank may be used only by the system port and the backdoor. Requests aimed at different banks proceed in the same cycle. When the backdoor collides with a core port on one bank, a per-bank round-robin flag picks the winner and the loser waits with ready low. A request to a bank the port may not use, or to an address outside both banks, is accepted at once and reported as an error.

Each bank holds 2^BANK_AW words (BANK_BYTES = 4 << BANK_AW bytes). With BANK_AW = 13 the lower bank covers 0x1FFF_8000 to 0x1FFF_FFFF and the upper bank 0x2000_0000 to 0x2000_7FFF. The default BANK_AW = 10 keeps the arrays small.

Top module: `sr2_ctrl`

## Requirements
- R1: While rst_n is low, and in the first clock cycle after rst_n rises, every p_ready, p_rvalid and p_err is 0.
- R2: The lower bank spans [SPLIT_ADDR - BANK_BYTES, SPLIT_ADDR) and the upper bank spans [SPLIT_ADDR, SPLIT_ADDR + BANK_BYTES). The word index is (address - bank base) >> 2, and a read returns the word last written at that index.
- R3: Port 0 may use only the lower bank, port 1 only the upper bank, and port 2 both banks.
- R4: A request that breaks R3, or whose address lies in neither bank, gets p_ready high in its request cycle and p_err high for exactly the next cycle, with no p_rvalid. It changes no memory word.
- R5: On a write, p_be bit i enables bits [8i+7:8i] of the addressed word. Bytes whose enable bit is 0 keep their old value.
- R6: An accepted legal read gives p_rvalid high for one cycle and p_rdata valid in the cycle after acceptance, on the requesting port only. Writes give no p_rvalid.
- R7: Legal requests from two ports that target different banks are both accepted in the same cycle.
- R8: Each bank has a priority flag that is 0 (core port favoured) at reset. Any grant of that bank to its core port sets the flag to 1 (backdoor favoured), and any grant to the backdoor clears it. On a collision, the favoured port gets p_ready high and the other gets p_ready low. If the loser holds its request, it is granted in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| p_valid | input | 3 | Request valid per port (0 code, 1 system, 2 backdoor) |
| p_we | input | 3 | Write flag per port |
| p_be | input | 3x4 | Byte-enable mask per port |
| p_addr | input | 3x32 | Byte address per port |
| p_wdata | input | 3x32 | Write data per port |
| p_ready | output | 3 | Request accepted this cycle |
| p_rvalid | output | 3 | Read data valid (one cycle after acceptance) |
| p_rdata | output | 3x32 | Read data |
| p_err | output | 3 | Error response (one cycle after acceptance) |

## Verification
A vector table first drives one port at a time. It writes and reads the first and last word of each bank from every permitted port, then sends forbidden-bank and out-of-range requests and partial byte masks. This separates decode errors, access-rule errors and byte-lane errors. Pairs of ports then request different banks in the same cycle, which shows whether the banks really work in parallel. Same-bank collisions follow, with the priority flag first favouring the core port and then the backdoor. These show whether the round-robin flag flips after each grant and whether a held loser is served in the very next cycle.

// File: rtl/sr2_pkg.sv
package sr2_pkg;

  localparam int NPORT = 3;
  localparam int NBANK = 2;

  typedef enum logic [1:0] {
    PORT_CODE = 2'd0,
    PORT_SYS  = 2'd1,
    PORT_BD   = 2'd2
  } port_e;

  // True when byte address a lies in [base, base + bytes)
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input logic [31:0] bytes);
    logic [31:0] off;
    off = a - base;
    return (a >= base) && (off < bytes);
  endfunction

endpackage

// File: rtl/sr2_decode.sv
module sr2_decode
  import sr2_pkg::*;
#(
  parameter logic [31:0] SPLIT_ADDR = 32'h2000_0000,
  parameter int          BANK_AW    = 10,
  parameter port_e       PORT       = PORT_CODE
) (
  input  logic [31:0]        addr,
  output logic               ok,
  output logic               bank,
  output logic [BANK_AW-1:0] idx
);
  localparam logic [31:0] BANK_BYTES = 32'(4) << BANK_AW;
  localparam logic [31:0] LO_BASE    = SPLIT_ADDR - BANK_BYTES;

  function automatic logic [BANK_AW-1:0] word_of(input logic [31:0] a,
                                                 input logic [31:0] base);
    logic [31:0] off;
    off = a - base;
    return off[BANK_AW+1:2];
  endfunction

  logic lo_hit, hi_hit;

  assign lo_hit = in_window(addr, LO_BASE, BANK_BYTES);
  assign hi_hit = in_window(addr, SPLIT_ADDR, BANK_BYTES);
  assign bank   = hi_hit;
  assign idx    = word_of(addr, hi_hit ? SPLIT_ADDR : LO_BASE);

  generate
    if (PORT == PORT_CODE) begin : g_code
      assign ok = lo_hit;
    end else if (PORT == PORT_SYS) begin : g_sys
      assign ok = hi_hit;
    end else begin : g_bd
      assign ok = lo_hit | hi_hit;
    end
  endgenerate

endmodule

// File: rtl/sr2_rr_arb.sv
module sr2_rr_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic core_req,
  input  logic bd_req,
  output logic core_gnt,
  output logic bd_gnt
);
  logic bd_pri;  // 1: backdoor favoured on collision

  assign core_gnt = core_req & (~bd_req | ~bd_pri);
  assign bd_gnt   = bd_req & (~core_req | bd_pri);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bd_pri <= 1'b0;
    else if (core_gnt) bd_pri <= 1'b1;
    else if (bd_gnt)   bd_pri <= 1'b0;
  end

endmodule

// File: rtl/sr2_bank.sv
module sr2_bank #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [3:0]    be,
  input  logic [AW-1:0] idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) begin
      for (int i = 0; i < 4; i++)
        if (be[i]) mem[idx][8*i +: 8] <= wdata[8*i +: 8];
    end
    if (en && !we) rdata <= mem[idx];
  end

endmodule

// File: rtl/sr2_ctrl.sv
module sr2_ctrl
  import sr2_pkg::*;
#(
  parameter logic [31:0] SPLIT_ADDR = 32'h2000_0000,
  parameter int          BANK_AW    = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            p_valid,
  input  logic [2:0]            p_we,
  input  logic [2:0][3:0]       p_be,
  input  logic [2:0][31:0]      p_addr,
  input  logic [2:0][31:0]      p_wdata,
  output logic [2:0]            p_ready,
  output logic [2:0]            p_rvalid,
  output logic [2:0][31:0]      p_rdata,
  output logic [2:0]            p_err
);
  // Named internal events, observed by the bound checker
  logic                        live;
  logic [NPORT-1:0]            port_ok;
  logic [NPORT-1:0]            port_bank;
  logic [NPORT-1:0][BANK_AW-1:0] port_idx;
  logic [NBANK-1:0]            bank_core_req, bank_bd_req;
  logic [NBANK-1:0]            bank_core_gnt, bank_bd_gnt;
  logic [NPORT-1:0]            port_gnt;
  logic [NBANK-1:0][31:0]      bank_rd;
  logic [NPORT-1:0]            src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    sr2_decode #(
      .SPLIT_ADDR(SPLIT_ADDR),
      .BANK_AW   (BANK_AW),
      .PORT      (port_e'(p))
    ) i_dec (
      .addr(p_addr[p]),
      .ok  (port_ok[p]),
      .bank(port_bank[p]),
      .idx (port_idx[p])
    );
  end

  // Bank b is shared by core port b and the backdoor (port 2)
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic               sel_bd;
    logic               en;
    logic               we;
    logic [3:0]         be;
    logic [BANK_AW-1:0] idx;
    logic [31:0]        wd;

    assign bank_core_req[b] = live & p_valid[b] & port_ok[b] &
                              (port_bank[b] == 1'(b));
    assign bank_bd_req[b]   = live & p_valid[PORT_BD] & port_ok[PORT_BD] &
                              (port_bank[PORT_BD] == 1'(b));

    sr2_rr_arb i_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .core_req(bank_core_req[b]),
      .bd_req  (bank_bd_req[b]),
      .core_gnt(bank_core_gnt[b]),
      .bd_gnt  (bank_bd_gnt[b])
    );

    assign sel_bd = bank_bd_gnt[b];
    assign en     = bank_core_gnt[b] | bank_bd_gnt[b];
    assign we     = sel_bd ? p_we[PORT_BD]     : p_we[b];
    assign be     = sel_bd ? p_be[PORT_BD]     : p_be[b];
    assign idx    = sel_bd ? port_idx[PORT_BD] : port_idx[b];
    assign wd     = sel_bd ? p_wdata[PORT_BD]  : p_wdata[b];

    sr2_bank #(.AW(BANK_AW)) i_mem (
      .clk  (clk),
      .en   (en),
      .we   (we),
      .be   (be),
      .idx  (idx),
      .wdata(wd),
      .rdata(bank_rd[b])
    );
  end

  assign port_gnt[PORT_CODE] = bank_core_gnt[0];
  assign port_gnt[PORT_SYS]  = bank_core_gnt[1];
  assign port_gnt[PORT_BD]   = |bank_bd_gnt;

  for (genvar p = 0; p < NPORT; p++) begin : g_resp
    assign p_ready[p] = live & p_valid[p] & (~port_ok[p] | port_gnt[p]);
    assign p_rdata[p] = src_q[p] ? bank_rd[1] : bank_rd[0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p_rvalid[p] <= 1'b0;
        p_err[p]    <= 1'b0;
        src_q[p]    <= 1'b0;
      end else begin
        p_rvalid[p] <= p_ready[p] & port_ok[p] & ~p_we[p];
        p_err[p]    <= p_ready[p] & ~port_ok[p];
        if (p_ready[p]) src_q[p] <= port_bank[p];
      end
    end
  end

endmodule

// File: rtl/sr2_ctrl_chk.sv
module sr2_ctrl_chk (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       p_valid,
  input logic [2:0]       p_we,
  input logic [2:0][31:0] p_addr,
  input logic [2:0]       p_ready,
  input logic [2:0]       p_rvalid,
  input logic [2:0]       p_err,
  input logic             live,
  input logic [2:0]       port_ok
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  // R1
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (p_ready == 3'b000));

  // R7
  parallel_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && p_valid[0] && port_ok[0] && p_valid[1] && port_ok[1] && !p_valid[2])
      |-> (p_ready[0] && p_ready[1]));

  for (genvar p = 0; p < 3; p++) begin : g_port
    // R6
    rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      p_rvalid[p] |-> $past(p_valid[p] && p_ready[p] && !p_we[p]));

    // R4
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      p_err[p] |-> ($past(p_ready[p]) && !p_rvalid[p]));

    // R8
    stall_then_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && p_valid[p] && !p_ready[p]) ##1
      (p_valid[p] && $stable(p_addr[p]) && $stable(p_we[p])) |-> p_ready[p]);
  end

endmodule

bind sr2_ctrl sr2_ctrl_chk i_sr2_ctrl_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .p_valid (p_valid),
  .p_we    (p_we),
  .p_addr  (p_addr),
  .p_ready (p_ready),
  .p_rvalid(p_rvalid),
  .p_err   (p_err),
  .live    (live),
  .port_ok (port_ok)
);

// File: tb/test_sr2_ctrl.sv
module test_sr2_ctrl;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       p_valid = '0;
  logic [2:0]       p_we = '0;
  logic [2:0][3:0]  p_be = '0;
  logic [2:0][31:0] p_addr = '0;
  logic [2:0][31:0] p_wdata = '0;
  logic [2:0]       p_ready, p_rvalid, p_err;
  logic [2:0][31:0] p_rdata;

  int n_chk = 0;
  int n_err = 0;
  logic [1:0] pri = 2'b00;  // bench copy of R8 flags, per bank

  always #4 clk = ~clk;  // 125 MHz

  sr2_ctrl #(.SPLIT_ADDR(32'h2000_0000), .BANK_AW(10)) i_sr2_ctrl (
    .clk(clk), .rst_n(rst_n), .p_valid(p_valid), .p_we(p_we), .p_be(p_be),
    .p_addr(p_addr), .p_wdata(p_wdata), .p_ready(p_ready),
    .p_rvalid(p_rvalid), .p_rdata(p_rdata), .p_err(p_err)
  );

  typedef struct packed {
    logic [1:0]  port;
    logic        we;
    logic [3:0]  be;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        exp_err;
    logic [31:0] exp_rd;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t [0:16] VECS = '{
    '{2'd0, 1'b1, 4'hF, 32'h1FFF_F000, 32'h1111_1111, 1'b0, 32'h0,         4'd2}, // R2 lower first
    '{2'd1, 1'b1, 4'hF, 32'h2000_0000, 32'h2222_2222, 1'b0, 32'h0,         4'd2}, // R2 upper first
    '{2'd2, 1'b1, 4'hF, 32'h1FFF_FFFC, 32'h3333_3333, 1'b0, 32'h0,         4'd3}, // R3 bd lower last
    '{2'd2, 1'b1, 4'hF, 32'h2000_0FFC, 32'h4444_4444, 1'b0, 32'h0,         4'd3}, // R3 bd upper last
    '{2'd0, 1'b0, 4'hF, 32'h1FFF_F000, 32'h0,         1'b0, 32'h1111_1111, 4'd6}, // R6
    '{2'd1, 1'b0, 4'hF, 32'h2000_0000, 32'h0,         1'b0, 32'h2222_2222, 4'd6}, // R6
    '{2'd2, 1'b0, 4'hF, 32'h1FFF_FFFC, 32'h0,         1'b0, 32'h3333_3333, 4'd2}, // R2
    '{2'd2, 1'b0, 4'hF, 32'h2000_0FFC, 32'h0,         1'b0, 32'h4444_4444, 4'd2}, // R2
    '{2'd0, 1'b1, 4'hF, 32'h2000_0000, 32'hDEAD_BEEF, 1'b1, 32'h0,         4'd3}, // R3 code->upper
    '{2'd1, 1'b1, 4'hF, 32'h1FFF_F000, 32'hDEAD_BEEF, 1'b1, 32'h0,         4'd3}, // R3 sys->lower
    '{2'd2, 1'b1, 4'hF, 32'h2000_1000, 32'hDEAD_BEEF, 1'b1, 32'h0,         4'd4}, // R4 above upper
    '{2'd2, 1'b0, 4'hF, 32'h1FFF_EFFC, 32'h0,         1'b1, 32'h0,         4'd4}, // R4 below lower
    '{2'd1, 1'b0, 4'hF, 32'h2000_0000, 32'h0,         1'b0, 32'h2222_2222, 4'd4}, // R4 unchanged
    '{2'd0, 1'b0, 4'hF, 32'h1FFF_F000, 32'h0,         1'b0, 32'h1111_1111, 4'd4}, // R4 unchanged
    '{2'd0, 1'b1, 4'h5, 32'h1FFF_F000, 32'hAABB_CCDD, 1'b0, 32'h0,         4'd5}, // R5 partial
    '{2'd2, 1'b0, 4'hF, 32'h1FFF_F000, 32'h0,         1'b0, 32'h11BB_11DD, 4'd5}, // R5 merged
    '{2'd0, 1'b0, 4'hF, 32'h1FFF_FFFC, 32'h0,         1'b0, 32'h3333_3333, 4'd3}  // R3 shared lower
  };

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int p, input logic we, input logic [3:0] be,
                       input logic [31:0] addr, input logic [31:0] wd);
    p_valid[p] = 1'b1; p_we[p] = we; p_be[p] = be;
    p_addr[p] = addr;  p_wdata[p] = wd;
  endtask

  task automatic idle(input int p);
    p_valid[p] = 1'b0; p_we[p] = 1'b0; p_be[p] = '0;
  endtask

  // bench record of a legal grant for R8
  function automatic void note_grant(input int p, input int b);
    pri[b] = (p == 2) ? 1'b0 : 1'b1;
  endfunction

  function automatic int bank_of(input logic [31:0] a);
    return (a >= 32'h2000_0000) ? 1 : 0;
  endfunction

  task automatic run_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d vec port%0d addr=%h", v.req, v.port, v.addr);
    @(posedge clk); #1;
    drive(v.port, v.we, v.be, v.addr, v.wdata);
    @(negedge clk);
    chk({tag, " ready"}, 32'(p_ready[v.port]), 32'd1);
    @(posedge clk); #1;
    idle(v.port);
    if (!v.exp_err) note_grant(v.port, bank_of(v.addr));
    @(negedge clk);
    chk({tag, " err"}, 32'(p_err[v.port]), 32'(v.exp_err));
    chk({tag, " rvalid"}, 32'(p_rvalid), (!v.we && !v.exp_err) ? (32'd1 << v.port) : 32'd0);
    if (!v.we && !v.exp_err) chk({tag, " rdata"}, p_rdata[v.port], v.exp_rd);
  endtask

  // two legal requests on different banks in the same cycle (R7)
  task automatic pair(input int pa, input int pb, input logic we,
                      input logic [31:0] aa, input logic [31:0] ab,
                      input logic [31:0] da, input logic [31:0] db);
    @(posedge clk); #1;
    drive(pa, we, 4'hF, aa, da);
    drive(pb, we, 4'hF, ab, db);
    @(negedge clk);
    chk("R7 pair ready", 32'({p_ready[pa], p_ready[pb]}), 32'd3);
    @(posedge clk); #1;
    idle(pa); idle(pb);
    note_grant(pa, bank_of(aa));
    note_grant(pb, bank_of(ab));
    @(negedge clk);
    if (!we) begin
      chk("R7 pair rvalid", 32'({p_rvalid[pa], p_rvalid[pb]}), 32'd3);
      chk("R7 pair rdata a", p_rdata[pa], da);
      chk("R7 pair rdata b", p_rdata[pb], db);
    end
  endtask

  // core port pc and backdoor read the same bank b (R8)
  task automatic contend(input int pc, input int b,
                         input logic [31:0] ac, input logic [31:0] abd,
                         input logic [31:0] ec, input logic [31:0] ebd);
    logic bd_wins;
    int w, l;
    logic [31:0] ew, el;
    bd_wins = pri[b];
    w  = bd_wins ? 2 : pc;   l  = bd_wins ? pc : 2;
    ew = bd_wins ? ebd : ec; el = bd_wins ? ec : ebd;
    @(posedge clk); #1;
    drive(pc, 1'b0, 4'hF, ac, 32'h0);
    drive(2, 1'b0, 4'hF, abd, 32'h0);
    @(negedge clk);
    chk("R8 winner ready", 32'(p_ready[w]), 32'd1);
    chk("R8 loser stalled", 32'(p_ready[l]), 32'd0);
    @(posedge clk); #1;
    idle(w);
    @(negedge clk);
    chk("R8 winner rdata", p_rdata[w], ew);
    chk("R8 winner rvalid", 32'(p_rvalid[w]), 32'd1);
    chk("R8 loser granted next", 32'(p_ready[l]), 32'd1);
    @(posedge clk); #1;
    idle(l);
    note_grant(l, b);
    @(negedge clk);
    chk("R8 loser rvalid", 32'(p_rvalid[l]), 32'd1);
    chk("R8 loser rdata", p_rdata[l], el);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R1: request held during reset and the first cycle after it
    drive(0, 1'b0, 4'hF, 32'h1FFF_F000, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 ready in reset", 32'(p_ready), 32'd0);
    chk("R1 rvalid/err in reset", 32'({p_rvalid, p_err}), 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready first cycle", 32'(p_ready), 32'd0);
    idle(0);
    @(posedge clk);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R7: different banks in parallel
    pair(0, 1, 1'b1, 32'h1FFF_F010, 32'h2000_0010, 32'hA0A0_A0A0, 32'hB0B0_B0B0);
    pair(0, 1, 1'b0, 32'h1FFF_F010, 32'h2000_0010, 32'hA0A0_A0A0, 32'hB0B0_B0B0);
    pair(0, 2, 1'b0, 32'h1FFF_F010, 32'h2000_0010, 32'hA0A0_A0A0, 32'hB0B0_B0B0);
    pair(1, 2, 1'b0, 32'h2000_0010, 32'h1FFF_F010, 32'hB0B0_B0B0, 32'hA0A0_A0A0);

    // R8: lower bank flag favours core, upper bank flag favours backdoor
    contend(0, 0, 32'h1FFF_F010, 32'h1FFF_FFFC, 32'hA0A0_A0A0, 32'h3333_3333);
    contend(1, 1, 32'h2000_0010, 32'h2000_0FFC, 32'hB0B0_B0B0, 32'h4444_4444);
    contend(0, 0, 32'h1FFF_F010, 32'h1FFF_FFFC, 32'hA0A0_A0A0, 32'h3333_3333);

    repeat (3) @(posedge clk);
    summary();
    $finish;
  end

endmodule